// File: doc/BRIEF.md
# Multi-Bank Configurable Clock Divider

This block takes one fast source clock and produces three divided clock outputs. Two wide banks (A and B) each take an independent 6-bit ratio code. A third, narrow bank (C) takes a 2-bit rate code. Wide-bank ratios are even, except for one code that gives an odd ratio. The odd case is built to give a near-50% duty cycle by combining a rising-edge state with a copy of it delayed by half a source period.

A bypass control replaces the fast source with a reference clock as the divider input. That reference is itself picked from three candidates: a single-ended external clock, a buffered differential external clock, or a crystal oscillator clock.

An active-low master reset forces every output low at once. When reset is released, all three banks start counting on the same divider-clock edge, so banks with related ratios begin phase-aligned. Ratio codes may be changed while the block runs. A new code is picked up only at the end of the current output period, so no output pulse is ever shorter than the old or the new setting.

Top module: `mbcd_top`

## Requirements
- R1: While `rst_n` is low, `out_a`, `out_b` and `out_c` are all low, and they go low without waiting for a clock edge.
- R2: For a code value k from 4 to 63 (other than 7) on `code_a` or `code_b`, taken as an unsigned binary number, that bank divides the divider clock by N = 2k. The output period is N divider-clock periods and the high time is N/2 periods. The two wide banks are set independently.
- R3: Code value 7 on a wide bank selects N = 15. The period is 15 divider-clock periods and the high time is 7.5 periods, with the falling edge on a falling edge of the divider clock.
- R4: Code values 0 to 3 on a wide bank are clamped to N = 8.
- R5: `rate_c` values 0, 1, 2 and 3 select N = 40, 16, 8 and 4 for bank C, each with a high time of N/2 periods.
- R6: A code change takes effect only after the output period in progress has ended. The period in progress keeps the old ratio, and the next period uses the new one.
- R7: On the first divider-clock rising edge after `rst_n` rises, all three outputs go high together.
- R8: With `bypass` high, the divider clock is the selected reference clock instead of `fast_clk`, and every ratio applies to that reference.
- R9: Reference choice: `sel_xtal` = 1 picks `xtal_clk`. Otherwise `sel_diff` = 1 picks `ref_diff_clk` and `sel_diff` = 0 picks `ref_se_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast source clock, used as the divider clock when not bypassed |
| ref_se_clk | input | 1 | Single-ended external reference clock |
| ref_diff_clk | input | 1 | Differential external reference, already converted to a single-ended signal |
| xtal_clk | input | 1 | Crystal oscillator reference clock |
| sel_diff | input | 1 | 1 picks the differential external reference over the single-ended one |
| sel_xtal | input | 1 | 1 picks the crystal reference over the external one |
| bypass | input | 1 | 1 feeds the selected reference to the dividers instead of `fast_clk` |
| rst_n | input | 1 | Active-low master reset |
| code_a | input | 6 | Bank A ratio code |
| code_b | input | 6 | Bank B ratio code |
| rate_c | input | 2 | Bank C rate code |
| out_a | output | 1 | Bank A divided clock |
| out_b | output | 1 | Bank B divided clock |
| out_c | output | 1 | Bank C divided clock |

## Verification
After reset is released, the outputs are due high exactly one divider-clock edge later. The bench releases reset on a falling edge and compares the recorded rise times against that edge time. A ratio change is not seen until the period in progress ends. So after each new code the bench lets four output rises pass, then compares the last full period and high time with N times the source period. For the change test it instead checks the first completed period against the old ratio and the second against the new one. Bypass and reference-select cases are changed only while reset is held, and are measured the same way against the chosen reference period.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;

    // Which code decoding a bank uses
    typedef enum logic {
        KIND_WIDE = 1'b0,
        KIND_RATE = 1'b1
    } bank_kind_e;

    // Reference clock candidates
    typedef enum logic [1:0] {
        SRC_SINGLE = 2'd0,
        SRC_DIFF   = 2'd1,
        SRC_XTAL   = 2'd2
    } ref_src_e;

endpackage

// File: rtl/mbcd_ref_sel.sv
module mbcd_ref_sel
    import mbcd_pkg::*;
(
    input  logic fast_clk_i,
    input  logic ref_se_i,
    input  logic ref_diff_i,
    input  logic xtal_i,
    input  logic sel_diff_i,
    input  logic sel_xtal_i,
    input  logic bypass_i,
    output logic div_clk_o
);

    ref_src_e src;
    logic     ref_clk;

    always_comb begin
        if (sel_xtal_i)      src = SRC_XTAL;
        else if (sel_diff_i) src = SRC_DIFF;
        else                 src = SRC_SINGLE;
    end

    always_comb begin
        case (src)
            SRC_XTAL: ref_clk = xtal_i;
            SRC_DIFF: ref_clk = ref_diff_i;
            default:  ref_clk = ref_se_i;
        endcase
    end

    // The source may only be switched while the dividers are held in reset.
    assign div_clk_o = bypass_i ? ref_clk : fast_clk_i;

endmodule

// File: rtl/mbcd_ratio_dec.sv
module mbcd_ratio_dec
    import mbcd_pkg::*;
#(
    parameter bank_kind_e KIND       = KIND_WIDE,
    parameter int         CODE_W     = 6,
    parameter int         RATIO_W    = 7,
    parameter int         ODD_CODE   = 7,
    parameter int         ODD_RATIO  = 15,
    parameter int         MIN_CODE   = 4,
    parameter int         BASE_RATIO = 4,
    parameter int         TEST_RATIO = 40
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o
);

    localparam logic [RATIO_W-1:0] CLAMP_RATIO = RATIO_W'(2 * MIN_CODE);

    if (KIND == KIND_WIDE) begin : g_wide
        always_comb begin
            if (code_i == CODE_W'(ODD_CODE)) begin
                ratio_o = RATIO_W'(ODD_RATIO);
            end else if (code_i < CODE_W'(MIN_CODE)) begin
                ratio_o = CLAMP_RATIO;
            end else begin
                ratio_o = RATIO_W'(code_i) << 1;
            end
        end
    end else begin : g_rate
        always_comb begin
            case (code_i)
                CODE_W'(0): ratio_o = RATIO_W'(TEST_RATIO);
                CODE_W'(1): ratio_o = RATIO_W'(BASE_RATIO << 2);
                CODE_W'(2): ratio_o = RATIO_W'(BASE_RATIO << 1);
                default:    ratio_o = RATIO_W'(BASE_RATIO);
            endcase
        end
    end

endmodule

// File: rtl/mbcd_div_core.sv
module mbcd_div_core #(
    parameter int RATIO_W = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               clk_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               fresh;
        logic               odd;
        logic               rise;
    } div_state_t;

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    div_state_t st_d, st_q;
    logic       fall_q;
    logic [RATIO_W-1:0] eff;
    logic       last;

    always_comb begin
        st_d  = st_q;
        // First cycle after reset takes the configured ratio directly
        eff   = st_q.fresh ? ratio_i : st_q.ratio;
        last  = (st_q.cnt == eff - ONE);
        st_d.rise  = (st_q.cnt < (eff >> 1));
        st_d.odd   = eff[0];
        st_d.cnt   = last ? '0 : st_q.cnt + ONE;
        // New ratio is only taken at a period boundary
        st_d.ratio = last ? ratio_i : eff;
        st_d.fresh = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, ratio: '0, fresh: 1'b1, odd: 1'b0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Half-period delayed copy that stretches odd-ratio pulses
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= st_q.rise;
        end
    end

    assign clk_o = st_q.rise | (st_q.odd & fall_q);

endmodule

// File: rtl/mbcd_top.sv
module mbcd_top
    import mbcd_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int RATE_W     = 2,
    parameter int ODD_CODE   = 7,
    parameter int ODD_RATIO  = 15,
    parameter int MIN_CODE   = 4,
    parameter int BASE_RATIO = 4,
    parameter int TEST_RATIO = 40
) (
    input  logic              fast_clk,
    input  logic              ref_se_clk,
    input  logic              ref_diff_clk,
    input  logic              xtal_clk,
    input  logic              sel_diff,
    input  logic              sel_xtal,
    input  logic              bypass,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic [RATE_W-1:0] rate_c,
    output logic              out_a,
    output logic              out_b,
    output logic              out_c
);

    localparam int RATIO_W   = CODE_W + 1;
    localparam int NUM_WIDE  = 2;
    localparam int NUM_BANKS = NUM_WIDE + 1;

    logic                 div_clk;
    logic [CODE_W-1:0]    code_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_out;

    mbcd_ref_sel u_ref_sel (
        .fast_clk_i (fast_clk),
        .ref_se_i   (ref_se_clk),
        .ref_diff_i (ref_diff_clk),
        .xtal_i     (xtal_clk),
        .sel_diff_i (sel_diff),
        .sel_xtal_i (sel_xtal),
        .bypass_i   (bypass),
        .div_clk_o  (div_clk)
    );

    assign code_arr[0] = code_a;
    assign code_arr[1] = code_b;
    assign code_arr[2] = CODE_W'(rate_c);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam bank_kind_e KIND = (b < NUM_WIDE) ? KIND_WIDE : KIND_RATE;
        logic [RATIO_W-1:0] ratio;

        mbcd_ratio_dec #(
            .KIND       (KIND),
            .CODE_W     (CODE_W),
            .RATIO_W    (RATIO_W),
            .ODD_CODE   (ODD_CODE),
            .ODD_RATIO  (ODD_RATIO),
            .MIN_CODE   (MIN_CODE),
            .BASE_RATIO (BASE_RATIO),
            .TEST_RATIO (TEST_RATIO)
        ) u_dec (
            .code_i  (code_arr[b]),
            .ratio_o (ratio)
        );

        mbcd_div_core #(
            .RATIO_W (RATIO_W)
        ) u_core (
            .clk_i   (div_clk),
            .rst_ni  (rst_n),
            .ratio_i (ratio),
            .clk_o   (bank_out[b])
        );
    end

    assign out_a = bank_out[0];
    assign out_b = bank_out[1];
    assign out_c = bank_out[2];

endmodule

// File: rtl/mbcd_chk.sv
module mbcd_chk #(
    parameter int MIN_RUN_WIDE = 4,
    parameter int MAX_RUN_WIDE = 64,
    parameter int MIN_RUN_RATE = 2,
    parameter int MAX_RUN_RATE = 20,
    parameter int RUN_W        = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic out_a_i,
    input logic out_b_i,
    input logic out_c_i
);

    logic [2:0]       outs;
    logic [2:0]       prev_q;
    logic [2:0]       seen_q;
    logic [RUN_W-1:0] run_q [3];

    assign outs = {out_c_i, out_b_i, out_a_i};

    for (genvar i = 0; i < 3; i++) begin : g_run
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                prev_q[i] <= 1'b0;
                seen_q[i] <= 1'b0;
                run_q[i]  <= '0;
            end else begin
                prev_q[i] <= outs[i];
                if (outs[i] != prev_q[i]) begin
                    run_q[i]  <= RUN_W'(1);
                    seen_q[i] <= 1'b1;
                end else if (run_q[i] != '1) begin
                    run_q[i] <= run_q[i] + RUN_W'(1);
                end
            end
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |-> (!out_a_i && !out_b_i && !out_c_i));

    // R7
    start_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |=> (out_a_i && out_b_i && out_c_i));

    // R4
    wide_a_min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q[0] && outs[0] != prev_q[0]) |-> run_q[0] >= RUN_W'(MIN_RUN_WIDE));

    // R4
    wide_b_min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q[1] && outs[1] != prev_q[1]) |-> run_q[1] >= RUN_W'(MIN_RUN_WIDE));

    // R2
    wide_a_max_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q[0] <= RUN_W'(MAX_RUN_WIDE));

    // R2
    wide_b_max_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q[1] <= RUN_W'(MAX_RUN_WIDE));

    // R5
    rate_max_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q[2] <= RUN_W'(MAX_RUN_RATE));

    // R5
    rate_min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q[2] && outs[2] != prev_q[2]) |-> run_q[2] >= RUN_W'(MIN_RUN_RATE));

endmodule

bind mbcd_top mbcd_chk u_chk (
    .clk_i   (div_clk),
    .rst_ni  (rst_n),
    .out_a_i (out_a),
    .out_b_i (out_b),
    .out_c_i (out_c)
);

// File: tb/mbcd_top_tb.sv
`timescale 1ns/1ps
module mbcd_top_tb;

    localparam real T_FAST = 8.0;
    localparam real T_SE   = 10.0;
    localparam real T_DIFF = 12.0;
    localparam real T_XTAL = 16.0;

    logic fast_clk = 1'b0, ref_se_clk = 1'b0, ref_diff_clk = 1'b0, xtal_clk = 1'b0;
    logic sel_diff = 1'b0, sel_xtal = 1'b0, bypass = 1'b0, rst_n = 1'b0;
    logic [5:0] code_a = 6'd10, code_b = 6'd20;
    logic [1:0] rate_c = 2'd3;
    logic out_a, out_b, out_c;
    logic [2:0] outs;

    int  n_checks = 0, n_fail = 0;
    bit  done = 1'b0;
    real rise_t [3];
    real per_t  [3];
    real hi_t   [3];
    int  n_rise [3];

    always #4 fast_clk     = ~fast_clk;
    always #5 ref_se_clk   = ~ref_se_clk;
    always #6 ref_diff_clk = ~ref_diff_clk;
    always #8 xtal_clk     = ~xtal_clk;

    mbcd_top u_dut (
        .fast_clk     (fast_clk),
        .ref_se_clk   (ref_se_clk),
        .ref_diff_clk (ref_diff_clk),
        .xtal_clk     (xtal_clk),
        .sel_diff     (sel_diff),
        .sel_xtal     (sel_xtal),
        .bypass       (bypass),
        .rst_n        (rst_n),
        .code_a       (code_a),
        .code_b       (code_b),
        .rate_c       (rate_c),
        .out_a        (out_a),
        .out_b        (out_b),
        .out_c        (out_c)
    );

    assign outs = {out_c, out_b, out_a};

    initial begin
        for (int i = 0; i < 3; i++) begin
            rise_t[i] = 0.0; per_t[i] = 0.0; hi_t[i] = 0.0; n_rise[i] = 0;
        end
    end

    always @(posedge out_a) begin per_t[0] = $realtime - rise_t[0]; rise_t[0] = $realtime; n_rise[0]++; end
    always @(posedge out_b) begin per_t[1] = $realtime - rise_t[1]; rise_t[1] = $realtime; n_rise[1]++; end
    always @(posedge out_c) begin per_t[2] = $realtime - rise_t[2]; rise_t[2] = $realtime; n_rise[2]++; end
    always @(negedge out_a) hi_t[0] = $realtime - rise_t[0];
    always @(negedge out_b) hi_t[1] = $realtime - rise_t[1];
    always @(negedge out_c) hi_t[2] = $realtime - rise_t[2];

    function automatic int wide_ratio(int k);
        if (k == 7) return 15;
        if (k < 4)  return 8;
        return 2 * k;
    endfunction

    function automatic int rate_ratio(int r);
        case (r)
            0: return 40;
            1: return 16;
            2: return 8;
            default: return 4;
        endcase
    endfunction

    function automatic string wide_tag(int k);
        if (k == 7) return "R3";
        if (k < 4)  return "R4";
        return "R2";
    endfunction

    task automatic check_close(string tag, string what, real act, real exp);
        n_checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            n_fail++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", tag, what, act, exp);
        end
    endtask

    task automatic check_bit(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Let four rises pass so a new code is certainly in force, then measure
    task automatic measure(int b, real tsrc, int n, string tag);
        int c0;
        c0 = n_rise[b];
        while (n_rise[b] < c0 + 4) @(negedge fast_clk);
        check_close(tag, $sformatf("bank%0d period N=%0d", b, n), per_t[b], n * tsrc);
        check_close(tag, $sformatf("bank%0d high N=%0d", b, n), hi_t[b], n * tsrc / 2.0);
    endtask

    task automatic wait_rises(int b, int k);
        int c0;
        c0 = n_rise[b];
        while (n_rise[b] < c0 + k) @(negedge fast_clk);
    endtask

    initial begin
        real t_rel;
        real tref;

        // R1: outputs low while reset held
        repeat (6) @(negedge fast_clk);
        for (int b = 0; b < 3; b++) check_bit("R1", $sformatf("bank%0d in reset", b), outs[b], 1'b0);

        // R7: release on a falling edge, all rise on the next rising edge
        t_rel = $realtime;
        rst_n = 1'b1;
        repeat (2) @(negedge fast_clk);
        for (int b = 0; b < 3; b++) begin
            check_close("R7", $sformatf("bank%0d first rise time", b), rise_t[b], t_rel + T_FAST / 2.0);
            check_bit("R7", $sformatf("bank%0d high after start", b), outs[b], 1'b1);
        end

        // R2 R3 R4: sweep every wide code, banks set differently
        for (int k = 0; k < 64; k++) begin
            code_a = 6'(k);
            code_b = 6'(63 - k);
            measure(0, T_FAST, wide_ratio(k), wide_tag(k));
            measure(1, T_FAST, wide_ratio(63 - k), wide_tag(63 - k));
        end

        // R5: every narrow-bank rate code
        for (int r = 0; r < 4; r++) begin
            rate_c = 2'(r);
            measure(2, T_FAST, rate_ratio(r), "R5");
        end

        // R6: change mid-period, old period completes first
        code_a = 6'd10;
        measure(0, T_FAST, 20, "R6");
        @(posedge out_a);
        #1 code_a = 6'd7;
        wait_rises(0, 1);
        check_close("R6", "period in progress keeps old ratio", per_t[0], 20 * T_FAST);
        wait_rises(0, 1);
        check_close("R6", "next period uses new ratio", per_t[0], 15 * T_FAST);
        check_close("R6", "next high uses new ratio", hi_t[0], 7.5 * T_FAST);

        // R1: asynchronous hold while running
        @(posedge out_c);
        #1 rst_n = 1'b0;
        #1;
        for (int b = 0; b < 3; b++) check_bit("R1", $sformatf("bank%0d async reset", b), outs[b], 1'b0);

        // R8 R9: bypass with each reference choice, switched under reset
        for (int s = 0; s < 4; s++) begin
            rst_n = 1'b0;
            bypass = 1'b1;
            sel_xtal = s[1];
            sel_diff = s[0];
            code_a = 6'd7;
            rate_c = 2'd3;
            tref = sel_xtal ? T_XTAL : (sel_diff ? T_DIFF : T_SE);
            repeat (8) @(negedge fast_clk);
            rst_n = 1'b1;
            measure(0, tref, 15, "R8");
            measure(2, tref, 4, "R9");
        end

        // Back to the fast source
        rst_n = 1'b0;
        bypass = 1'b0;
        sel_xtal = 1'b0;
        sel_diff = 1'b0;
        repeat (4) @(negedge fast_clk);
        rst_n = 1'b1;
        code_b = 6'd5;
        measure(1, T_FAST, 10, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge fast_clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule